// File: doc/BRIEF.md
# Masked-Flag Condition Evaluator

This block decides whether a conditional instruction should take effect. It looks at two fields of the current instruction word and at three status flags. The first field is an opcode, and the condition can only hold when that opcode is all zeros. The second field is a mask that selects which flags count. The condition holds when at least one selected flag is set. It can be used as the trigger for a branch, a skip or any other operation that depends on the flags.

The block also holds the flag register. On a write strobe the register loads new flags derived from a 16-bit result word:
- negative is taken from the sign bit of the result;
- zero is set when every bit of the result is clear;
- parity is set when the result has an even count of ones.

The decision is presented in two forms. The first is combinational and follows the instruction and the stored flags within the same cycle. The second is registered and gives the previous cycle's decision, for consumers that need a clean flop boundary.

Top module: `cond_branch_eval`

## Requirements
- R1: While `rst_n` is low, and directly after it rises, all three flags are 0 and `take_q_o` is 0. As a result, `take_o` is 0 for every instruction until the flags are first written.
- R2: `take_o` is 0 whenever any of the opcode bits `instr_i[15:12]` is 1, whatever the mask and flag values.
- R3: When the opcode is zero, each mask bit gates one flag, and `take_o` is 1 exactly when a gated flag is set:
  - `instr_i[11]` selects negative;
  - `instr_i[10]` selects zero;
  - `instr_i[9]` selects parity.
- R4: A mask of 000 never asserts `take_o`, for any flag contents.
- R5: A mask with several bits set asserts `take_o` when any one of its selected flags is set. For example, mask 110 is true on negative or zero.
- R6: Instruction bits `instr_i[8:0]` have no effect on `take_o`.
- R7: On a rising clock edge with `flag_we_i` high, the flags load from `result_i`:
  - negative = `result_i[15]`;
  - zero = (`result_i` == 0);
  - parity = 1 when `result_i` holds an even number of ones.
- R8: On a rising edge with `flag_we_i` low, the flags keep their values, whatever `result_i` holds.
- R9: `take_q_o` equals the value `take_o` had during the previous clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| instr_i | input | 16 | Current instruction word |
| flag_we_i | input | 1 | Flag register write enable |
| result_i | input | 16 | Result word that the flags are derived from |
| take_o | output | 1 | Combinational condition decision |
| take_q_o | output | 1 | Decision registered one cycle later |

## Verification
The flags are not visible at the ports. A wrong flag value therefore shows up only when the opcode is zero and the instruction's mask selects that flag, and then it appears on `take_o` in the same cycle. Single-bit masks are used to read each flag back right after every load and after every held cycle. This puts a bad load, a bad hold or a wrong derivation within one cycle of the edge that caused it. A fault in the output flop shows on `take_q_o` one cycle after the decision it copies.

// File: rtl/cond_eval_pkg.sv
package cond_eval_pkg;
  localparam int unsigned INSTR_W  = 16;
  localparam int unsigned OPC_W    = 4;
  localparam int unsigned MASK_W   = 3;
  localparam int unsigned RESULT_W = 16;

  // Flag order matters: it lines up with the mask bits, highest first.
  typedef struct packed {
    logic neg;
    logic zero;
    logic par;
  } cond_flags_t;
endpackage

// File: rtl/status_flags.sv
module status_flags
  import cond_eval_pkg::*;
#(
  parameter int unsigned RES_W = RESULT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we_i,
  input  logic [RES_W-1:0] result_i,
  output cond_flags_t      flags_o
);
  localparam int unsigned SIGN_BIT = RES_W - 1;

  cond_flags_t flags_d;
  cond_flags_t flags_q;
  cond_flags_t flags_load;

  // Derive the new flags from the result word.
  always_comb begin
    flags_load.neg  = result_i[SIGN_BIT];
    flags_load.zero = (result_i == '0);
    flags_load.par  = ~(^result_i);
  end

  // Next state: load when enabled, otherwise hold.
  always_comb begin
    flags_d = flags_q;
    if (we_i) begin
      flags_d = flags_load;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
    end else begin
      flags_q <= flags_d;
    end
  end

  assign flags_o = flags_q;

  // R8
  a_r8_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
    !we_i |=> $stable(flags_q));

  // R7
  a_r7_zero_result: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && result_i == '0) |=> (flags_q.zero && !flags_q.neg && flags_q.par));

  // R7
  a_r7_sign_loaded: assert property (@(posedge clk) disable iff (!rst_n)
    we_i |=> (flags_q.neg == $past(result_i[SIGN_BIT])));
endmodule

// File: rtl/cond_match.sv
module cond_match
  import cond_eval_pkg::*;
#(
  parameter int unsigned IW = INSTR_W,
  parameter int unsigned OW = OPC_W,
  parameter int unsigned MW = MASK_W
) (
  input  logic [IW-1:0] instr_i,
  input  cond_flags_t   flags_i,
  output logic          take_o
);
  localparam int unsigned OPC_LSB  = IW - OW;
  localparam int unsigned MASK_MSB = OPC_LSB - 1;
  localparam int unsigned MASK_LSB = OPC_LSB - MW;

  logic [OW-1:0] opcode;
  logic [MW-1:0] mask;
  logic [MW-1:0] flag_vec;
  logic [MW-1:0] gated;
  logic          opc_zero;

  assign opcode   = instr_i[IW-1:OPC_LSB];
  assign mask     = instr_i[MASK_MSB:MASK_LSB];
  assign flag_vec = flags_i;
  assign opc_zero = ~(|opcode);

  // One gate per mask bit.
  for (genvar g = 0; g < MW; g++) begin : g_gate
    assign gated[g] = mask[g] & flag_vec[g];
  end

  assign take_o = opc_zero & (|gated);

  // R4: an empty mask never fires.
  always_comb begin
    a_r4_empty_mask: assert (!(mask == '0 && take_o));
  end
endmodule

// File: rtl/take_reg.sv
module take_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic take_i,
  output logic take_q_o
);
  logic take_d;
  logic take_q;

  assign take_d = take_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      take_q <= 1'b0;
    end else begin
      take_q <= take_d;
    end
  end

  assign take_q_o = take_q;

  // R9
  a_r9_delayed_copy: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (take_q == $past(take_i)));
endmodule

// File: rtl/cond_branch_eval.sv
module cond_branch_eval
  import cond_eval_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [INSTR_W-1:0]  instr_i,
  input  logic                flag_we_i,
  input  logic [RESULT_W-1:0] result_i,
  output logic                take_o,
  output logic                take_q_o
);
  cond_flags_t flags;
  logic        take_comb;

  status_flags #(.RES_W(RESULT_W)) u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .we_i     (flag_we_i),
    .result_i (result_i),
    .flags_o  (flags)
  );

  cond_match #(.IW(INSTR_W), .OW(OPC_W), .MW(MASK_W)) u_match (
    .instr_i (instr_i),
    .flags_i (flags),
    .take_o  (take_comb)
  );

  take_reg u_take_q (
    .clk      (clk),
    .rst_n    (rst_n),
    .take_i   (take_comb),
    .take_q_o (take_q_o)
  );

  assign take_o = take_comb;

  // R2
  a_r2_opcode_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_i[INSTR_W-1 -: OPC_W] != '0) |-> !take_o);

  // R1: flags are clear while reset is applied
  always_comb begin
    if (!rst_n) a_r1_reset_clear: assert (!take_q_o && flags == '0);
  end
endmodule

// File: tb/cond_branch_eval_tb.sv
module cond_branch_eval_tb;
  logic        clk;
  logic        rst_n;
  logic [15:0] instr_i;
  logic        flag_we_i;
  logic [15:0] result_i;
  logic        take_o;
  logic        take_q_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  bit    exp_q[$];
  string tag_q[$];

  logic mn, mz, mp;

  cond_branch_eval u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .instr_i   (instr_i),
    .flag_we_i (flag_we_i),
    .result_i  (result_i),
    .take_o    (take_o),
    .take_q_o  (take_q_o)
  );

  initial clk = 0;
  always #5 clk = ~clk;

  function automatic bit model_take(logic [15:0] ins);
    logic [2:0] m;
    m = ins[11:9];
    return (ins[15:12] == 4'd0) && ((m[2] && mn) || (m[1] && mz) || (m[0] && mp));
  endfunction

  task automatic check(bit act, bit exp, string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  // Driver: one cycle per call, pushes the expected decision.
  task automatic drive(logic [15:0] ins, logic we, logic [15:0] res, string tag);
    @(negedge clk);
    instr_i   = ins;
    flag_we_i = we;
    result_i  = res;
    exp_q.push_back(model_take(ins));
    tag_q.push_back(tag);
    if (we) begin
      mn = res[15];
      mz = (res == 16'd0);
      mp = ($countones(res) % 2) == 0;
    end
  endtask

  // Monitor: samples 3 ns after the driving edge.
  initial begin
    bit    prev_valid;
    bit    prev_exp;
    bit    e;
    string t;
    prev_valid = 0;
    prev_exp = 0;
    forever begin
      @(negedge clk);
      #3;
      if (exp_q.size() > 0) begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(take_o, e, t);
        if (prev_valid) check(take_q_o, prev_exp, "R9 registered copy");
        prev_valid = 1;
        prev_exp = e;
      end else begin
        prev_valid = 0;
      end
    end
  end

  // Watchdog
  initial begin
    #2000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] loads [5];
    loads[0] = 16'h0001; // N0 Z0 P0
    loads[1] = 16'h0003; // N0 Z0 P1
    loads[2] = 16'h8000; // N1 Z0 P0
    loads[3] = 16'h8001; // N1 Z0 P1
    loads[4] = 16'h0000; // N0 Z1 P1
    mn = 0; mz = 0; mp = 0;
    rst_n = 0; instr_i = 16'h0E00; flag_we_i = 0; result_i = 16'h0;
    repeat (3) @(posedge clk);
    #2;
    check(take_o, 1'b0, "R1 take during reset");
    check(take_q_o, 1'b0, "R1 take_q during reset");
    @(negedge clk);
    rst_n = 1;
    drive(16'h0E00, 1'b0, 16'h0, "R1 all-mask after reset");
    drive(16'h0E00, 1'b0, 16'h0, "R1 second cycle after reset");

    for (int f = 0; f < 5; f++) begin
      drive(16'hF1FF, 1'b1, loads[f], "R7 load cycle");
      // R7 single-mask readback of each flag
      drive(16'h0800, 1'b0, 16'h5555, "R7 negative readback");
      drive(16'h0400, 1'b0, 16'h5555, "R7 zero readback");
      drive(16'h0200, 1'b0, 16'h5555, "R7 parity readback");
      for (int op = 0; op < 2; op++) begin
        for (int m = 0; m < 8; m++) begin
          logic [15:0] ins;
          ins[15:12] = (op == 0) ? 4'd0 : 4'((m + f) % 15 + 1);
          ins[11:9]  = 3'(m);
          ins[8:0]   = 9'((m * 37 + f * 91) & 9'h1FF); // R6 varied low bits
          if (op != 0)      drive(ins, 1'b0, 16'h0, "R2 nonzero opcode");
          else if (m == 0)  drive(ins, 1'b0, 16'h0, "R4 empty mask");
          else if (m == 3 || m >= 5) drive(ins, 1'b0, 16'h0, "R5 multi-bit mask");
          else              drive(ins, 1'b0, 16'h0, "R3 single mask");
        end
      end
      // R8: hold with a different result on the bus
      drive(16'h0E00, 1'b0, loads[(f + 2) % 5], "R8 hold cycle");
      drive(16'h0800, 1'b0, 16'h0, "R8 negative held");
      drive(16'h0400, 1'b0, 16'h0, "R8 zero held");
      drive(16'h0200, 1'b0, 16'h0, "R8 parity held");
      // R6: same decision with all low bits set and cleared
      drive(16'h0C00, 1'b0, 16'h0, "R6 low bits clear");
      drive(16'h0DFF, 1'b0, 16'h0, "R6 low bits set");
    end
    // R7 parity on wider patterns
    drive(16'h0000, 1'b1, 16'h00FF, "R7 load even");
    drive(16'h0200, 1'b0, 16'h0, "R7 even parity");
    drive(16'h0000, 1'b1, 16'h0007, "R7 load odd");
    drive(16'h0200, 1'b0, 16'h0, "R7 odd parity");
    drive(16'h0000, 1'b1, 16'hFFFF, "R7 load all ones");
    drive(16'h0C00, 1'b0, 16'h0, "R5 not-positive on negative");
    drive(16'h0600, 1'b0, 16'h0, "R5 zero or parity");
    repeat (3) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule